// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit executes the four single-bit test instructions of a general-purpose integer core on a 16-bit or 32-bit operand. The four instructions are plain test, test-and-set, test-and-reset and test-and-complement. A single datapath handles all four. The unit picks one bit of the operand from a bit index and copies that bit's previous value into the carry flag. It then produces the rewritten word and a write-enable that tells the write-back stage to store it.

In memory mode, the bit index can point outside the operand. In that case the unit also produces a signed word offset, and the address stage adds it to the operand's base address. In register mode, only the position of the bit inside the word matters.

Results are presented for exactly one cycle, one clock edge after the request. Each result carries a flag-write mask so that the flag logic updates carry and keeps every other flag as it was.

Top module: `bit_test_unit`

## Requirements
- R1: The selected bit position is the bit index modulo the operand width: index bits [3:0] when `in_wide`=0 (16-bit), index bits [4:0] when `in_wide`=1 (32-bit).
- R2: When `in_mem`=1, `out_offset` is the bit index arithmetically shifted right by 4 (16-bit) or by 5 (32-bit), so a negative index gives a negative word offset.
- R3: When `in_mem`=0, `out_offset` is zero whatever the index.
- R4: `out_carry` equals the value the selected bit had in the input word before any change.
- R5: Operation codes on `in_op`: 2'b00 test, 2'b01 set, 2'b10 reset, 2'b11 complement. Set forces the selected bit to 1, reset forces it to 0, and complement inverts it. Codes 01, 10 and 11 raise `out_we`.
- R6: For test (2'b00), `out_we` is 0 and `out_word` equals the input word of the operand width.
- R7: `out_word` is the full operand-width word, and every bit other than the selected one is copied unchanged. In 16-bit mode, bits [31:16] of `out_word` are 0 and do not depend on the input.
- R8: `out_flag_mask` is 6'b000001 for every result (bit 0 = carry), so no other flag is written.
- R9: A request sampled with `in_valid`=1 on a rising edge makes `out_valid` high for exactly the following cycle, with all result outputs valid in that cycle. After reset, `out_valid` is 0 and the result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_word | input | 32 | Operand word (low 16 bits used in 16-bit mode) |
| in_index | input | 32 | Signed bit index |
| in_op | input | 2 | Operation code |
| in_wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit |
| in_mem | input | 1 | 1 = memory operand, 0 = register operand |
| out_valid | output | 1 | Result strobe, one cycle per request |
| out_word | output | 32 | Word to write back |
| out_we | output | 1 | Write-back enable |
| out_carry | output | 1 | Previous value of the selected bit |
| out_offset | output | 32 | Signed word offset to the addressed word |
| out_flag_mask | output | 6 | Flags written by this result |

## Verification
Every result field is due on the first rising edge after the edge that samples the request. The bench drives inputs and reads outputs on falling edges, so a request driven at one falling edge is visible on the outputs at the next falling edge. The driver pushes the expected item into a queue when it applies the request. The monitor pops one item at every falling edge where `out_valid` is high, and fails if there is a result pulse with no pending item or if items are still pending at the end. This holds single-cycle timing exact through back-to-back runs as well as isolated requests.

// File: rtl/btu_pkg.sv
// Package: shared operation codes and flag layout for the bit test unit.
// Assumes a six-flag status word with carry at bit 0.
package btu_pkg;
    typedef enum logic [1:0] {
        BT_TEST = 2'b00,
        BT_SET  = 2'b01,
        BT_CLR  = 2'b10,
        BT_FLIP = 2'b11
    } bt_op_e;

    localparam int FLAG_N    = 6;
    localparam int CARRY_BIT = 0;
endpackage

// File: rtl/btu_locate.sv
// btu_locate: turns a signed bit index into an in-word bit position and,
// for memory operands, a signed word offset. Assumes DATA_W is a power
// of two and the narrow operand is DATA_W/2 wide.
module btu_locate #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 32,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic signed [IDX_W-1:0] idx,
    input  logic                    wide,
    input  logic                    mem,
    output logic [POS_W-1:0]        pos,
    output logic signed [IDX_W-1:0] offset
);
    logic signed [IDX_W-1:0] ofs_full;
    logic signed [IDX_W-1:0] ofs_half;

    // Purpose: bit position is the index modulo the operand width.
    always_comb begin
        if (wide) pos = idx[POS_W-1:0];
        else      pos = {1'b0, idx[POS_W-2:0]};
    end

    // Purpose: floor division of the index by the width, only for memory mode.
    always_comb begin
        ofs_full = idx >>> POS_W;
        ofs_half = idx >>> (POS_W - 1);
        if (!mem)      offset = '0;
        else if (wide) offset = ofs_full;
        else           offset = ofs_half;
    end
endmodule

// File: rtl/btu_modify.sv
// btu_modify: reads the selected bit into carry and forms the rewritten word
// for the requested operation. Assumes pos already lies inside the operand
// width; narrow operands have their upper half forced to zero.
module btu_modify
    import btu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int POS_W  = $clog2(DATA_W),
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] word,
    input  logic [POS_W-1:0]  pos,
    input  bt_op_e            op,
    input  logic              wide,
    output logic [DATA_W-1:0] new_word,
    output logic              we,
    output logic              carry
);
    logic [DATA_W-1:0] eff;
    logic [DATA_W-1:0] hit;

    // Per-bit slice: operand-width masking, selection and rewrite.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i >= HALF_W) begin : g_upper
            assign eff[i] = wide & word[i];
        end else begin : g_lower
            assign eff[i] = word[i];
        end
        assign hit[i] = (pos == POS_W'(i));

        // Purpose: apply the operation to the selected bit, pass others through.
        always_comb begin
            if (!hit[i]) begin
                new_word[i] = eff[i];
            end else begin
                unique case (op)
                    BT_SET:  new_word[i] = 1'b1;
                    BT_CLR:  new_word[i] = 1'b0;
                    BT_FLIP: new_word[i] = ~eff[i];
                    default: new_word[i] = eff[i];
                endcase
            end
        end
    end

    // Purpose: capture old bit value and decide on write-back.
    always_comb begin
        carry = |(eff & hit);
        we    = (op != BT_TEST);
    end
endmodule

// File: rtl/btu_outreg.sv
// btu_outreg: one-cycle result register with a single-cycle valid strobe.
// Assumes synchronous active-low reset; fields load only on a request.
module btu_outreg
    import btu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    d_word,
    input  logic                 d_we,
    input  logic                 d_carry,
    input  logic [IDX_W-1:0]     d_offset,
    input  logic [FLAG_N-1:0]    d_mask,
    output logic                 q_valid,
    output logic [DATA_W-1:0]    q_word,
    output logic                 q_we,
    output logic                 q_carry,
    output logic [IDX_W-1:0]     q_offset,
    output logic [FLAG_N-1:0]    q_mask
);
    // Purpose: strobe follows the request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= in_valid;
    end

    // Purpose: hold result fields from the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_word   <= '0;
            q_we     <= 1'b0;
            q_carry  <= 1'b0;
            q_offset <= '0;
            q_mask   <= '0;
        end else if (in_valid) begin
            q_word   <= d_word;
            q_we     <= d_we;
            q_carry  <= d_carry;
            q_offset <= d_offset;
            q_mask   <= d_mask;
        end
    end

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> q_valid);
    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !q_valid);
endmodule

// File: rtl/bit_test_unit.sv
// bit_test_unit: top level of the bit test/set/reset/complement unit.
// Locates the bit, rewrites the operand and registers the result for one
// cycle. Assumes in_op uses the btu_pkg encoding and requests may arrive
// every cycle.
module bit_test_unit
    import btu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 32,
    localparam int POS_W  = $clog2(DATA_W),
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_word,
    input  logic [IDX_W-1:0]  in_index,
    input  logic [1:0]        in_op,
    input  logic              in_wide,
    input  logic              in_mem,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_word,
    output logic              out_we,
    output logic              out_carry,
    output logic [IDX_W-1:0]  out_offset,
    output logic [FLAG_N-1:0] out_flag_mask
);
    bt_op_e                  op_e;
    logic [POS_W-1:0]        pos;
    logic signed [IDX_W-1:0] ofs;
    logic [DATA_W-1:0]       new_word;
    logic                    we;
    logic                    carry;
    logic [FLAG_N-1:0]       mask;

    // Purpose: decode the op code and build the carry-only flag mask.
    always_comb begin
        op_e = bt_op_e'(in_op);
        mask = '0;
        mask[CARRY_BIT] = 1'b1;
    end

    btu_locate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_locate (
        .idx    (in_index),
        .wide   (in_wide),
        .mem    (in_mem),
        .pos    (pos),
        .offset (ofs)
    );

    btu_modify #(.DATA_W(DATA_W)) u_modify (
        .word     (in_word),
        .pos      (pos),
        .op       (op_e),
        .wide     (in_wide),
        .new_word (new_word),
        .we       (we),
        .carry    (carry)
    );

    btu_outreg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .d_word   (new_word),
        .d_we     (we),
        .d_carry  (carry),
        .d_offset (ofs),
        .d_mask   (mask),
        .q_valid  (out_valid),
        .q_word   (out_word),
        .q_we     (out_we),
        .q_carry  (out_carry),
        .q_offset (out_offset),
        .q_mask   (out_flag_mask)
    );

    p_test_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op == 2'b00 |=> !out_we && out_word == $past(in_word) | {HALF_W{1'b0}}
            || !$past(in_wide));
    p_modify_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op != 2'b00 |=> out_we);
    p_reg_no_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_mem |=> out_offset == '0);
    p_narrow_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_wide |=> out_word[DATA_W-1:HALF_W] == '0);
    p_carry_only_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> $countones(out_flag_mask) == 1 && out_flag_mask[CARRY_BIT]);
endmodule

// File: tb/bit_test_unit_tb.sv
module bit_test_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [31:0] in_index = '0;
    logic [1:0]  in_op = '0;
    logic        in_wide = 1'b0;
    logic        in_mem = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_we;
    logic        out_carry;
    logic [31:0] out_offset;
    logic [5:0]  out_flag_mask;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [31:0] word;
        logic        we;
        logic        carry;
        logic [31:0] ofs;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    bit_test_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_index(in_index), .in_op(in_op), .in_wide(in_wide), .in_mem(in_mem),
        .out_valid(out_valid), .out_word(out_word), .out_we(out_we),
        .out_carry(out_carry), .out_offset(out_offset), .out_flag_mask(out_flag_mask)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one request at a falling edge and queue its expected result.
    task automatic drive(input logic [31:0] w, input logic [31:0] idx,
                         input logic [1:0] op, input logic wide, input logic mem);
        exp_t e;
        logic [31:0] ew;
        int p;
        @(negedge clk);
        in_word = w; in_index = idx; in_op = op; in_wide = wide; in_mem = mem;
        in_valid = 1'b1;
        ew = wide ? w : {16'h0, w[15:0]};            // R7 operand width
        p  = wide ? int'(idx[4:0]) : int'(idx[3:0]); // R1 position
        e.carry = ew[p];                               // R4
        e.we = (op != 2'b00);                          // R5 R6
        case (op)
            2'b01: ew[p] = 1'b1;
            2'b10: ew[p] = 1'b0;
            2'b11: ew[p] = ~ew[p];
            default: ;
        endcase
        e.word = ew;
        if (!mem) e.ofs = '0;                          // R3
        else      e.ofs = wide ? 32'($signed(idx) >>> 5) : 32'($signed(idx) >>> 4); // R2
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each result pulse against the oldest queued item.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R9 unexpected out_valid", 32'(out_valid), 32'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(out_word == e.word, "R5 R7 word", out_word, e.word);
                chk(out_we == e.we, "R6 we", 32'(out_we), 32'(e.we));
                chk(out_carry == e.carry, "R1 R4 carry", 32'(out_carry), 32'(e.carry));
                chk(out_offset == e.ofs, "R2 R3 offset", out_offset, e.ofs);
                chk(out_flag_mask == 6'b000001, "R8 mask", 32'(out_flag_mask), 32'h1);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R9 watchdog expired act=%h exp=%h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 reset valid", 32'(out_valid), 32'h0);
        chk(out_word == '0, "R9 reset word", out_word, 32'h0);
        rst_n = 1'b1;
        idle(1);
        chk(out_valid == 1'b0, "R9 idle valid", 32'(out_valid), 32'h0);

        drive(32'h0000_0000, 32'd31, 2'b01, 1'b1, 1'b0);  // R5 set top bit
        idle(2);
        drive(32'hFFFF_FFFF, 32'd15, 2'b10, 1'b0, 1'b0);  // R7 narrow upper cleared
        drive(32'hA5A5_A5A5, 32'd2, 2'b11, 1'b1, 1'b0);   // R5 complement back-to-back
        drive(32'h1234_8000, 32'd15, 2'b00, 1'b0, 1'b1);  // R6 test, R2 offset 0
        drive(32'h0000_0010, 32'd100, 2'b00, 1'b0, 1'b1); // R1 pos 4, R2 offset 6
        drive(32'h0000_0010, 32'd100, 2'b10, 1'b0, 1'b0); // R3 register no offset
        drive(32'h0000_8000, 32'hFFFF_FFFF, 2'b11, 1'b0, 1'b1); // R2 index -1 -> -1
        drive(32'h8000_0000, 32'hFFFF_FFDF, 2'b10, 1'b1, 1'b1); // R2 index -33 -> -2
        drive(32'h0000_0001, 32'd64, 2'b00, 1'b1, 1'b1);  // R1 wrap pos 0, R2 offset 2
        idle(1);
        chk(out_valid == 1'b1, "R9 last pulse", 32'(out_valid), 32'h1);
        idle(1);
        chk(out_valid == 1'b0, "R9 single pulse", 32'(out_valid), 32'h0);

        for (int n = 0; n < 60; n++) begin
            drive($urandom, $urandom, 2'($urandom), 1'($urandom), 1'($urandom));
            if (n % 7 == 3) idle(1);
        end
        idle(3);
        chk(q.size() == 0, "R9 all results delivered", 32'(q.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule